// File: doc/BRIEF.md
# Cross-Segment Hit Merger and Frame Buffer

This block is the second stage of a two-stage zero-suppression chain in a pixel sensor read out one row at a time. Each row, a bank of segment finders (one per 64-column slice of a 1088-column line) offers a short list of four-pixel windows that crossed threshold. The merger captures all of these lists in one cycle. It walks the lists in segment order and keeps no more than nine windows for the whole row. It packs the kept windows into 16-bit words behind a row header.

The words go into four 512-word banks, used as two pairs. One pair fills with the current frame while the other is shifted out on a serial line, most significant bit first. A frame-end pulse swaps the roles of the two pairs. If a pair runs out of room, the rows that follow are dropped and a sticky full flag is raised until the next swap.

Inputs are flat vectors indexed by slot, where slot = segment * 6 + window. A segment's windows are expected in ascending column order within its six slots.

Top module: `hit_merge_buffer`

## Requirements
- R1: Kept windows appear in ascending segment order and, within a segment, in ascending slot order. Each data word carries the global start column, computed as segment * 64 + local column.
- R2: At most nine data words are stored per row. Any further valid window in that row is discarded, and the header's overflow bit (bit 0) is set to 1.
- R3: A header word has bit 15 = 1, the row number in bits 14:5, the kept-window count in bits 4:1 and the overflow flag in bit 0. A data word has bit 15 = 0, the global column in bits 14:4 and the window mask in bits 3:0.
- R4: Each row is stored as its header followed directly by its data words. Rows within a frame are stored back to back in arrival order.
- R5: On a frame-end swap, the pair that was filling is shifted out and carries exactly the number of words written into it. A frame with no stored words sends nothing.
- R6: Each word is sent MSB first, one bit per cycle while serValid is high. serFrameStart is high only together with the first bit of a frame.
- R7: A row is accepted only if the filling pair has room for ten more words; otherwise the row is dropped whole and bufFull rises. bufFull stays high until the next swap clears it.
- R8: A frame end that arrives in the same cycle as a row strobe, or while a row is being merged, belongs after that row. The row goes out in the ending frame. The swap waits until the row is stored and the transmitter is idle.
- R9: While a row is being merged or a swap is pending, busy is high and row strobes are ignored.
- R10: After reset, busy, bufFull, serValid and serFrameStart are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStrobe | input | 1 | One-cycle pulse: the window lists of a new row are present |
| rowNum | input | 10 | Row number of the offered row |
| winValid | input | 102 | Valid flag per slot |
| winCol | input | 612 | Local start column per slot, 6 bits each |
| winMask | input | 408 | Four-pixel hit mask per slot, 4 bits each |
| frameEnd | input | 1 | One-cycle pulse closing the current frame |
| busy | output | 1 | Merging a row or a swap is pending |
| bufFull | output | 1 | Sticky: a row was dropped for lack of room in this frame |
| serData | output | 1 | Serial data bit |
| serValid | output | 1 | serData carries a bit this cycle |
| serFrameStart | output | 1 | First bit of a frame |

## Verification
The frame-end swap and the capture of a row can fall in the same cycle. The same conflict arises when the frame end comes during the hundred-odd cycles of a merge. The bench provokes both cases by driving frameEnd together with rowStrobe, and by driving it a few cycles into a merge. It judges the result by decoding the serial stream: the row must appear complete in the frame that was closing. The bench also offers a row while a deferred swap waits for the transmitter, and the stream of the following frame must not contain that row.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int WORD_W = 16;
  localparam int ROW_W  = 10;
  localparam int CNT_W  = 4;
  localparam int GCOL_W = 11;
  localparam int MASK_W = 4;

  typedef struct packed {
    logic capture;
    logic drop;
    logic step;
    logic header;
    logic swap;
  } hmbStrobe_t;

  function automatic logic [WORD_W-1:0] packHeader(logic [ROW_W-1:0] row,
                                                   logic [CNT_W-1:0] cnt,
                                                   logic ovf);
    return {1'b1, row, cnt, ovf};
  endfunction

  function automatic logic [WORD_W-1:0] packData(logic [GCOL_W-1:0] col,
                                                 logic [MASK_W-1:0] mask);
    return {1'b0, col, mask};
  endfunction
endpackage

// File: rtl/hmb_ctrl.sv
module hmb_ctrl
  import hmb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowStrobe,
  input  logic       frameEnd,
  input  logic       roomOk,
  input  logic       lastSlot,
  input  logic       txBusy,
  output hmbStrobe_t strobe,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_HDR} state_t;
  state_t state, stateNext;
  logic   swapPend;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (rowStrobe && !swapPend) begin
          if (roomOk) begin
            strobe.capture = 1'b1;
            stateNext      = S_SCAN;
          end else begin
            strobe.drop = 1'b1;
          end
        end else if (swapPend && !txBusy) begin
          strobe.swap = 1'b1;
        end
      end
      S_SCAN: begin
        strobe.step = 1'b1;
        if (lastSlot) stateNext = S_HDR;
      end
      S_HDR: begin
        strobe.header = 1'b1;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      swapPend <= 1'b0;
    end else begin
      state    <= stateNext;
      swapPend <= strobe.swap ? frameEnd : (swapPend | frameEnd);
    end
  end

  assign busy = (state != S_IDLE) || swapPend;

  // R9: no row is taken while a swap waits
  p_no_capture_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !swapPend);
  // R8: the swap never cuts into a draining pair
  p_swap_tx_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swap |-> !txBusy);
  // R8: a merge runs to its header before anything else happens
  p_scan_to_header_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SCAN && lastSlot) |=> strobe.header);
endmodule

// File: rtl/hmb_datapath.sv
module hmb_datapath
  import hmb_pkg::*;
#(
  parameter int NSEG      = 17,
  parameter int SEG_WIN   = 6,
  parameter int SEG_COLS  = 64,
  parameter int KEEP      = 9,
  parameter int MEM_DEPTH = 512,
  localparam int NSLOT      = NSEG * SEG_WIN,
  localparam int SLOT_W     = $clog2(NSLOT),
  localparam int SEG_W      = $clog2(NSEG),
  localparam int WIN_W      = $clog2(SEG_WIN),
  localparam int COL_W      = $clog2(SEG_COLS),
  localparam int PAIR_DEPTH = 2 * MEM_DEPTH,
  localparam int PAW        = $clog2(PAIR_DEPTH),
  localparam int CW         = $clog2(PAIR_DEPTH + KEEP + 2)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  hmbStrobe_t                strobe,
  input  logic [ROW_W-1:0]          rowNum,
  input  logic [NSLOT-1:0]          winValid,
  input  logic [NSLOT*COL_W-1:0]    winCol,
  input  logic [NSLOT*MASK_W-1:0]   winMask,
  input  logic [PAW-1:0]            rdAddr,
  output logic                      roomOk,
  output logic                      lastSlot,
  output logic [CW-1:0]             fillCount,
  output logic [WORD_W-1:0]         rdData,
  output logic                      bufFull
);
  logic [ROW_W-1:0]        capRow;
  logic [NSLOT-1:0]        capValid;
  logic [NSLOT*COL_W-1:0]  capCol;
  logic [NSLOT*MASK_W-1:0] capMask;
  logic [SLOT_W-1:0]       slotIdx;
  logic [SEG_W-1:0]        segIdx;
  logic [WIN_W-1:0]        winIdx;
  logic [CNT_W-1:0]        kept;
  logic                    ovf;
  logic [CW-1:0]           base;
  logic                    fillSel;
  logic                    full;

  logic                    curValid;
  logic [COL_W-1:0]        curCol;
  logic [MASK_W-1:0]       curMask;
  logic [GCOL_W-1:0]       gcol;
  logic                    keepIt;
  logic                    wrEn;
  logic [CW-1:0]           wrAddr;
  logic [WORD_W-1:0]       wrData;

  // four banks: index = {pair, half, word}
  logic [WORD_W-1:0] bankMem [4*MEM_DEPTH];

  assign curValid = capValid[slotIdx];
  assign curCol   = capCol[slotIdx*COL_W +: COL_W];
  assign curMask  = capMask[slotIdx*MASK_W +: MASK_W];
  assign gcol     = GCOL_W'(segIdx) * GCOL_W'(SEG_COLS) + GCOL_W'(curCol);
  assign keepIt   = strobe.step && curValid && (kept < CNT_W'(KEEP));
  assign wrEn     = keepIt || strobe.header;
  assign wrAddr   = strobe.header ? base : base + CW'(kept) + CW'(1);
  assign wrData   = strobe.header ? packHeader(capRow, kept, ovf)
                                  : packData(gcol, curMask);

  assign roomOk    = (base + CW'(KEEP + 1)) <= CW'(PAIR_DEPTH);
  assign lastSlot  = slotIdx == SLOT_W'(NSLOT - 1);
  assign fillCount = base;
  assign bufFull   = full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capRow   <= '0;
      capValid <= '0;
      capCol   <= '0;
      capMask  <= '0;
      slotIdx  <= '0;
      segIdx   <= '0;
      winIdx   <= '0;
      kept     <= '0;
      ovf      <= 1'b0;
      base     <= '0;
      fillSel  <= 1'b0;
      full     <= 1'b0;
    end else begin
      if (strobe.capture) begin
        capRow   <= rowNum;
        capValid <= winValid;
        capCol   <= winCol;
        capMask  <= winMask;
        slotIdx  <= '0;
        segIdx   <= '0;
        winIdx   <= '0;
        kept     <= '0;
        ovf      <= 1'b0;
      end
      if (strobe.step) begin
        if (keepIt)        kept <= kept + CNT_W'(1);
        else if (curValid) ovf  <= 1'b1;
        slotIdx <= slotIdx + SLOT_W'(1);
        if (winIdx == WIN_W'(SEG_WIN - 1)) begin
          winIdx <= '0;
          segIdx <= segIdx + SEG_W'(1);
        end else begin
          winIdx <= winIdx + WIN_W'(1);
        end
      end
      if (strobe.header) base <= base + CW'(kept) + CW'(1);
      if (strobe.drop)   full <= 1'b1;
      if (strobe.swap) begin
        fillSel <= ~fillSel;
        base    <= '0;
        full    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) bankMem[{fillSel, wrAddr[PAW-1:0]}] <= wrData;
    rdData <= bankMem[{~fillSel, rdAddr}];
  end

  // R7: every write lands inside the filling pair
  p_write_in_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr < CW'(PAIR_DEPTH));
  // R2: the per-row count never passes the cap
  p_kept_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    kept <= CNT_W'(KEEP));
  // R7: full is sticky until a swap
  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strobe.swap) |=> full);
endmodule

// File: rtl/hmb_serial_tx.sv
module hmb_serial_tx
  import hmb_pkg::*;
#(
  parameter int CW  = 11,
  parameter int PAW = 10,
  localparam int BIT_W = $clog2(WORD_W)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CW-1:0]     count,
  input  logic [WORD_W-1:0] rdData,
  output logic [PAW-1:0]    rdAddr,
  output logic              serData,
  output logic              serValid,
  output logic              serFrameStart,
  output logic              busy
);
  typedef enum logic [1:0] {T_IDLE, T_FETCH, T_LOAD, T_SHIFT} txState_t;
  txState_t          state;
  logic [CW-1:0]     addr;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] shreg;
  logic [BIT_W-1:0]  bitCnt;
  logic              first;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= T_IDLE;
      addr   <= '0;
      cnt    <= '0;
      shreg  <= '0;
      bitCnt <= '0;
      first  <= 1'b0;
    end else begin
      case (state)
        T_IDLE: if (start && count != '0) begin
          cnt   <= count;
          addr  <= '0;
          first <= 1'b1;
          state <= T_FETCH;
        end
        T_FETCH: state <= T_LOAD;
        T_LOAD: begin
          shreg  <= rdData;
          bitCnt <= '0;
          state  <= T_SHIFT;
        end
        T_SHIFT: begin
          shreg  <= {shreg[WORD_W-2:0], 1'b0};
          bitCnt <= bitCnt + BIT_W'(1);
          first  <= 1'b0;
          if (bitCnt == BIT_W'(WORD_W - 1)) begin
            addr  <= addr + CW'(1);
            state <= (addr + CW'(1) == cnt) ? T_IDLE : T_FETCH;
          end
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  assign rdAddr        = addr[PAW-1:0];
  assign serData       = shreg[WORD_W-1];
  assign serValid      = state == T_SHIFT;
  assign serFrameStart = serValid && first;
  assign busy          = state != T_IDLE;

  // R6: the frame marker only rides on a data bit
  p_start_with_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    serFrameStart |-> serValid);
  // R5: reads stay below the written word count
  p_read_in_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == T_FETCH) |-> addr < cnt);
endmodule

// File: rtl/hit_merge_buffer.sv
module hit_merge_buffer
  import hmb_pkg::*;
#(
  parameter int NSEG      = 17,
  parameter int SEG_WIN   = 6,
  parameter int SEG_COLS  = 64,
  parameter int KEEP      = 9,
  parameter int MEM_DEPTH = 512,
  localparam int NSLOT      = NSEG * SEG_WIN,
  localparam int COL_W      = $clog2(SEG_COLS),
  localparam int PAIR_DEPTH = 2 * MEM_DEPTH,
  localparam int PAW        = $clog2(PAIR_DEPTH),
  localparam int CW         = $clog2(PAIR_DEPTH + KEEP + 2)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rowStrobe,
  input  logic [ROW_W-1:0]        rowNum,
  input  logic [NSLOT-1:0]        winValid,
  input  logic [NSLOT*COL_W-1:0]  winCol,
  input  logic [NSLOT*MASK_W-1:0] winMask,
  input  logic                    frameEnd,
  output logic                    busy,
  output logic                    bufFull,
  output logic                    serData,
  output logic                    serValid,
  output logic                    serFrameStart
);
  hmbStrobe_t        strobe;
  logic              roomOk, lastSlot, txBusy;
  logic [CW-1:0]     fillCount;
  logic [PAW-1:0]    rdAddr;
  logic [WORD_W-1:0] rdData;

  hmb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rowStrobe(rowStrobe), .frameEnd(frameEnd),
    .roomOk(roomOk), .lastSlot(lastSlot), .txBusy(txBusy),
    .strobe(strobe), .busy(busy)
  );

  hmb_datapath #(.NSEG(NSEG), .SEG_WIN(SEG_WIN), .SEG_COLS(SEG_COLS),
                 .KEEP(KEEP), .MEM_DEPTH(MEM_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowNum(rowNum),
    .winValid(winValid), .winCol(winCol), .winMask(winMask),
    .rdAddr(rdAddr), .roomOk(roomOk), .lastSlot(lastSlot),
    .fillCount(fillCount), .rdData(rdData), .bufFull(bufFull)
  );

  hmb_serial_tx #(.CW(CW), .PAW(PAW)) u_tx (
    .clk(clk), .rstN(rstN), .start(strobe.swap), .count(fillCount),
    .rdData(rdData), .rdAddr(rdAddr), .serData(serData),
    .serValid(serValid), .serFrameStart(serFrameStart), .busy(txBusy)
  );
endmodule

// File: tb/hit_merge_buffer_tb.sv
module hit_merge_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 17;
  localparam int SW  = 6;
  localparam int NSL = NS * SW;
  localparam int NV  = 8;
  // fields: row[35:26] segment select[25:9] windows per segment[8:6] first local column[5:0]
  localparam logic [35:0] VEC [NV] = '{
    {10'd5,    17'h00001, 3'd1, 6'd3},
    {10'd1023, 17'h10000, 3'd2, 6'd10},
    {10'd100,  17'h00007, 3'd3, 6'd0},
    {10'd200,  17'h10021, 3'd4, 6'd2},
    {10'd0,    17'h00000, 3'd0, 6'd0},
    {10'd512,  17'h1FFFF, 3'd6, 6'd23},
    {10'd77,   17'h00208, 3'd5, 6'd1},
    {10'd300,  17'h00180, 3'd1, 6'd63}
  };

  logic clk = 1'b0, rstN = 1'b0, rowStrobe = 1'b0, frameEnd = 1'b0;
  logic [9:0] rowNum = '0;
  logic [NSL-1:0] winValid = '0;
  logic [NSL*6-1:0] winCol = '0;
  logic [NSL*4-1:0] winMask = '0;
  logic busy, bufFull, serData, serValid, serFrameStart;

  int nChecks = 0, nErrors = 0;
  logic [15:0] expW [64];
  int expN = 0;
  logic [15:0] rxW [64];
  logic [15:0] rxCur = '0;
  int rxWords = 0, rxBits = 0, fsCnt = 0, fsBad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_merge_buffer #(.MEM_DEPTH(16)) u_dut (
    .clk(clk), .rstN(rstN), .rowStrobe(rowStrobe), .rowNum(rowNum),
    .winValid(winValid), .winCol(winCol), .winMask(winMask),
    .frameEnd(frameEnd), .busy(busy), .bufFull(bufFull),
    .serData(serData), .serValid(serValid), .serFrameStart(serFrameStart)
  );

  always @(negedge clk) begin
    if (rstN && serValid) begin
      if (serFrameStart) begin
        fsCnt++;
        if (rxBits != 0 || rxWords != 0) fsBad++;
      end
      rxCur = {rxCur[14:0], serData};
      rxBits++;
      if (rxBits == 16) begin
        if (rxWords < 64) rxW[rxWords] = rxCur;
        rxWords++;
        rxBits = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearRx();
    rxWords = 0; rxBits = 0; fsCnt = 0; fsBad = 0; expN = 0;
  endtask

  task automatic driveRow(input logic [35:0] v);
    rowNum = v[35:26];
    for (int seg = 0; seg < NS; seg++)
      for (int s = 0; s < SW; s++) begin
        winValid[seg*SW+s]      = v[9+seg] && (s < int'(v[8:6]));
        winCol[(seg*SW+s)*6 +: 6] = 6'(int'(v[5:0]) + 8*s);
        winMask[(seg*SW+s)*4 +: 4] = 4'((seg + s) % 15 + 1);
      end
  endtask

  task automatic expectRow(input logic [35:0] v);
    int k = 0;
    logic ov = 1'b0;
    int h = expN;
    expN++;
    for (int seg = 0; seg < NS; seg++)
      for (int s = 0; s < SW; s++)
        if (v[9+seg] && s < int'(v[8:6])) begin
          if (k < 9) begin
            expW[expN] = {1'b0, 11'(seg*64 + int'(v[5:0]) + 8*s), 4'((seg + s) % 15 + 1)};
            expN++; k++;
          end else ov = 1'b1;
        end
    expW[h] = {1'b1, v[35:26], 4'(k), ov};
  endtask

  task automatic sendRow(input logic withEnd);
    @(negedge clk); rowStrobe = 1'b1; frameEnd = withEnd;
    @(negedge clk); rowStrobe = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic endFrame();
    @(negedge clk); frameEnd = 1'b1;
    @(negedge clk); frameEnd = 1'b0;
  endtask

  task automatic waitIdle();
    int g = 0;
    while (busy && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic collect(input string tag);
    int g = 0;
    while (rxWords < expN && g < expN*20 + 80) begin @(negedge clk); g++; end
    repeat (60) @(negedge clk);
    chk({tag, " R5 word count"}, rxWords, expN);
    for (int i = 0; i < expN && i < rxWords && i < 64; i++)
      chk({tag, " R1 R3 R6 word"}, int'(rxW[i]), int'(expW[i]));
    chk({tag, " R6 frame start count"}, fsCnt, (expN > 0) ? 1 : 0);
    chk({tag, " R6 frame start position"}, fsBad, 0);
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 bufFull", int'(bufFull), 0);
    chk("R10 serValid", int'(serValid), 0);
    chk("R10 serFrameStart", int'(serFrameStart), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: one row per frame (R1 R2 R3 R5 R6)
    for (int i = 0; i < NV; i++) begin
      clearRx();
      driveRow(VEC[i]);
      expectRow(VEC[i]);
      sendRow(1'b0);
      chk("R9 busy during merge", int'(busy), 1);
      waitIdle();
      endFrame();
      collect($sformatf("vec%0d", i));
    end

    // R4: several rows in one frame, back to back
    clearRx();
    driveRow(VEC[0]); expectRow(VEC[0]); sendRow(1'b0); waitIdle();
    driveRow(VEC[2]); expectRow(VEC[2]); sendRow(1'b0); waitIdle();
    driveRow(VEC[7]); expectRow(VEC[7]); sendRow(1'b0); waitIdle();
    endFrame();
    collect("R4 multi-row");

    // R7: pair of 32 words holds three ten-word rows; the fourth is dropped
    clearRx();
    for (int r = 1; r <= 4; r++) begin
      logic [35:0] v = {10'(r), VEC[5][25:0]};
      driveRow(v);
      if (r < 4) expectRow(v);
      sendRow(1'b0);
      if (r == 3) begin
        waitIdle();
        chk("R7 not full before drop", int'(bufFull), 0);
      end
      if (r == 4) begin
        chk("R7 bufFull after drop", int'(bufFull), 1);
        chk("R7 dropped row not merged", int'(busy), 0);
      end
      waitIdle();
    end
    repeat (5) @(negedge clk);
    chk("R7 bufFull sticky", int'(bufFull), 1);
    endFrame();
    collect("R7 full frame");
    chk("R7 bufFull cleared by swap", int'(bufFull), 0);

    // R8: frame end in the same cycle as the row strobe
    clearRx();
    driveRow(VEC[3]); expectRow(VEC[3]);
    sendRow(1'b1);
    waitIdle();
    collect("R8 same cycle");

    // R8: frame end in the middle of a merge
    clearRx();
    driveRow(VEC[6]); expectRow(VEC[6]);
    sendRow(1'b0);
    repeat (5) @(negedge clk);
    endFrame();
    waitIdle();
    collect("R8 mid merge");

    // R5: an empty frame sends nothing
    clearRx();
    endFrame();
    waitIdle();
    repeat (60) @(negedge clk);
    chk("R5 empty frame words", rxWords, 0);
    chk("R5 empty frame start", fsCnt, 0);

    // R9: a row offered while a swap waits on the transmitter is ignored
    clearRx();
    driveRow(VEC[2]); expectRow(VEC[2]);
    sendRow(1'b0); waitIdle();
    endFrame(); waitIdle();
    repeat (3) @(negedge clk);
    endFrame();
    chk("R9 busy while swap pending", int'(busy), 1);
    driveRow(VEC[0]);
    sendRow(1'b0);
    waitIdle();
    endFrame();
    waitIdle();
    repeat (300) @(negedge clk);
    chk("R9 ignored row absent", rxWords, expN);
    for (int i = 0; i < expN && i < rxWords; i++)
      chk("R9 first frame word", int'(rxW[i]), int'(expW[i]));

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule